// File: doc/BRIEF.md
# Receive Frame Status FIFO

This block keeps one descriptor for every frame that a DMA-driven receiver completes. When the receiver signals the end of a frame, the block stores the frame's byte count and its error flags as a single entry. Up to eight entries can wait for the CPU. Frame payload moves to memory by DMA. The CPU uses these descriptors to find where each frame ends in the buffer and whether it arrived intact.

Two interrupts tell the CPU when to service the queue:

- **Threshold interrupt.** Raised when the number of stored entries reaches a level that software selects.
- **Idle interrupt.** Raised when the stored entries stay below that level and no frame has ended for one millisecond. This covers a short burst of frames that never reaches the level.

The CPU drains one entry with three reads, in a fixed order:

1. The high length byte.
2. The low length byte.
3. The status byte. This read removes the entry.

The status byte reports an empty marker, so the CPU knows when to stop. A separate empty line lets the CPU dismiss an idle interrupt that found nothing pending.

Top module: `rx_frame_status_fifo`

## Requirements
- R1: After reset the queue is empty: `fifo_empty` is 1, `thr_irq` and `tmo_irq` are 0, and `rd_data` is 0 while no read strobe is high.
- R2: A `frame_end` pulse with fewer than DEPTH (8) entries stored appends the entry {`frame_len`, `frame_err`}. Entries leave in arrival order.
- R3: `rd_data` reflects the oldest entry in the same cycle as the strobe:
  - `rd_len_hi` gives length bits 11:8 in `rd_data[3:0]`, with bits 7:4 zero.
  - `rd_len_lo` gives length bits 7:0.
  - `rd_stat` gives the error flags in bits 3:0, the empty marker in bit 4 and the overflow flag in bit 5, with bits 7:6 zero.
  - If several strobes are high, `rd_len_hi` wins over `rd_len_lo`, which wins over `rd_stat`.
  - With no strobe high, `rd_data` is 0.
- R4: A clock edge with `rd_stat` high and the queue non-empty removes the oldest entry. Length reads never remove an entry.
- R5: `rd_stat` on an empty queue returns bit 4 set, error bits zero and the current overflow flag in bit 5. It changes no entry.
- R6: `thr_sel` selects the threshold level, and `thr_irq` is 1 exactly while the stored count is at or above that level:

  | `thr_sel` | Level |
  |---|---|
  | 0 | 1 |
  | 1 | 4 |
  | 2 | 7 |
  | 3 | 8 |

- R7: An idle timer restarts on every `frame_end` and on every removal.
  - `tmo_irq` is 1 while the timer has counted CYC_PER_MS cycles since the last restart, the queue is non-empty and the count is below the selected level.
  - It falls after the next `frame_end` or removal.
- R8: A `frame_end` that arrives while DEPTH entries are stored is discarded, even if a removal happens in the same cycle. It sets a sticky overflow flag.
  - The flag shows in status bit 5 and clears after a `rd_stat` read.
  - If the flag is set and read in the same cycle, it stays set.
- R9: `fifo_empty` is 1 exactly when no entry is stored.
- R10: A `frame_end` and a removing `rd_stat` in the same cycle on a non-full queue both take effect, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle pulse at the end of a received frame |
| frame_len | input | LEN_W (12) | Byte count of the ending frame |
| frame_err | input | ERR_W (4) | Error flags of the ending frame |
| thr_sel | input | 2 | Threshold level select (0:1, 1:4, 2:7, 3:8) |
| rd_len_hi | input | 1 | CPU read strobe for the high length byte |
| rd_len_lo | input | 1 | CPU read strobe for the low length byte |
| rd_stat | input | 1 | CPU read strobe for the status byte; removes the entry |
| rd_data | output | 8 | Read data for the strobe that is active |
| fifo_empty | output | 1 | High when no entry is stored |
| thr_irq | output | 1 | Count at or above the selected level |
| tmo_irq | output | 1 | Idle time-out with entries pending below the level |

## Verification
The bound checker watches several invariants in every cycle:
- The count never goes past the depth.
- A write into an empty queue clears the empty line.
- A removal without a write lowers the count by one.
- A write into a full queue leaves the count at the depth.
- The idle interrupt never coexists with an empty queue or with the threshold interrupt, and it drops after a frame end.
- An empty status read shows the empty marker.

Only the bench scenarios can show the rest:
- The byte layout of each stored entry and the arrival order across a full drain.
- The exact cycle at which the idle interrupt rises.
- The mapping of each level code.
- The sticky overflow flag appearing once and then clearing.
- The behaviour of a simultaneous write and removal.

// File: rtl/rfsf_pkg.sv
package rfsf_pkg;

    typedef enum logic [1:0] {
        LVL_ONE  = 2'd0,
        LVL_HALF = 2'd1,
        LVL_NEAR = 2'd2,
        LVL_ALL  = 2'd3
    } lvl_sel_e;

    // Map a level code to an entry count for a queue of the given depth.
    function automatic int unsigned lvl_to_count(input logic [1:0] sel, input int unsigned depth);
        case (lvl_sel_e'(sel))
            LVL_ONE:  return 1;
            LVL_HALF: return depth / 2;
            LVL_NEAR: return depth - 1;
            default:  return depth;
        endcase
    endfunction

endpackage

// File: rtl/rfsf_ring.sv
module rfsf_ring #(
    parameter int DEPTH = 8,
    parameter int LEN_W = 12,
    parameter int ERR_W = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = LEN_W + ERR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             clr_ovf,
    input  logic [LEN_W-1:0] in_len,
    input  logic [ERR_W-1:0] in_err,
    output logic [LEN_W-1:0] head_len,
    output logic [ERR_W-1:0] head_err,
    output logic [CNT_W-1:0] occ,
    output logic             is_empty,
    output logic             ovf
);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            occ;
        logic                        ovf;
    } ring_t;

    ring_t s_d, s_q;
    logic  full_w, empty_w, push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full_w  = (s_q.occ == CNT_W'(DEPTH));
    assign empty_w = (s_q.occ == '0);

    always_comb begin
        s_d     = s_q;
        push_ok = push_req && !full_w;
        pop_ok  = pop_req && !empty_w;
        if (push_ok) begin
            s_d.mem[s_q.wr] = {in_len, in_err};
            s_d.wr          = nxt(s_q.wr);
        end
        if (pop_ok) begin
            s_d.rd = nxt(s_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.occ = s_q.occ + CNT_W'(1);
            2'b01:   s_d.occ = s_q.occ - CNT_W'(1);
            default: s_d.occ = s_q.occ;
        endcase
        if (push_req && full_w) begin
            s_d.ovf = 1'b1;
        end else if (clr_ovf) begin
            s_d.ovf = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_len = s_q.mem[s_q.rd][ENT_W-1:ERR_W];
    assign head_err = s_q.mem[s_q.rd][ERR_W-1:0];
    assign occ      = s_q.occ;
    assign is_empty = empty_w;
    assign ovf      = s_q.ovf;

endmodule

// File: rtl/rfsf_idle_timer.sv
module rfsf_idle_timer #(
    parameter int LIMIT = 200000,
    localparam int TMR_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic arm,
    output logic fire
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic expired;

    assign expired = (t_q.cnt == TMR_W'(LIMIT));

    always_comb begin
        t_d = t_q;
        if (restart) begin
            t_d.cnt = '0;
        end else if (!expired) begin
            t_d.cnt = t_q.cnt + TMR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign fire = expired && arm;

endmodule

// File: rtl/rfsf_readout.sv
module rfsf_readout #(
    parameter int LEN_W = 12,
    parameter int ERR_W = 4
) (
    input  logic             sel_hi,
    input  logic             sel_lo,
    input  logic             sel_st,
    input  logic [LEN_W-1:0] head_len,
    input  logic [ERR_W-1:0] head_err,
    input  logic             empty,
    input  logic             ovf,
    output logic [7:0]       byte_out
);

    logic [15:0] len16;
    logic [7:0]  stat;

    always_comb begin
        len16 = empty ? 16'd0 : 16'(head_len);
        stat  = '0;
        stat[ERR_W-1:0] = empty ? '0 : head_err;
        stat[4] = empty;
        stat[5] = ovf;
        if (sel_hi) begin
            byte_out = len16[15:8];
        end else if (sel_lo) begin
            byte_out = len16[7:0];
        end else if (sel_st) begin
            byte_out = stat;
        end else begin
            byte_out = '0;
        end
    end

endmodule

// File: rtl/rx_frame_status_fifo.sv
module rx_frame_status_fifo #(
    parameter int DEPTH      = 8,
    parameter int LEN_W      = 12,
    parameter int ERR_W      = 4,
    parameter int CYC_PER_MS = 200000,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [ERR_W-1:0] frame_err,
    input  logic [1:0]       thr_sel,
    input  logic             rd_len_hi,
    input  logic             rd_len_lo,
    input  logic             rd_stat,
    output logic [7:0]       rd_data,
    output logic             fifo_empty,
    output logic             thr_irq,
    output logic             tmo_irq
);

    logic [LEN_W-1:0] head_len;
    logic [ERR_W-1:0] head_err;
    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] level;
    logic             ovf;
    logic             restart;

    rfsf_ring #(
        .DEPTH (DEPTH),
        .LEN_W (LEN_W),
        .ERR_W (ERR_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (frame_end),
        .pop_req  (rd_stat),
        .clr_ovf  (rd_stat),
        .in_len   (frame_len),
        .in_err   (frame_err),
        .head_len (head_len),
        .head_err (head_err),
        .occ      (occ),
        .is_empty (fifo_empty),
        .ovf      (ovf)
    );

    assign level   = CNT_W'(rfsf_pkg::lvl_to_count(thr_sel, DEPTH));
    assign thr_irq = (occ >= level);
    assign restart = frame_end || (rd_stat && !fifo_empty);

    rfsf_idle_timer #(
        .LIMIT (CYC_PER_MS)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .arm     (!fifo_empty && !thr_irq),
        .fire    (tmo_irq)
    );

    rfsf_readout #(
        .LEN_W (LEN_W),
        .ERR_W (ERR_W)
    ) u_rd (
        .sel_hi   (rd_len_hi),
        .sel_lo   (rd_len_lo),
        .sel_st   (rd_stat),
        .head_len (head_len),
        .head_err (head_err),
        .empty    (fifo_empty),
        .ovf      (ovf),
        .byte_out (rd_data)
    );

endmodule

// File: rtl/rfsf_checker.sv
module rfsf_checker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_end,
    input logic             rd_stat,
    input logic             rd_len_hi,
    input logic             rd_len_lo,
    input logic [7:0]       rd_data,
    input logic             fifo_empty,
    input logic             thr_irq,
    input logic             tmo_irq,
    input logic [CNT_W-1:0] occ
);

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    // R9
    empty_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty && frame_end |=> !fifo_empty);

    // R4
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat && !fifo_empty && !frame_end |=> occ == $past(occ) - CNT_W'(1));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) && frame_end && !rd_stat |=> occ == CNT_W'(DEPTH));

    // R7
    tmo_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> !fifo_empty && !thr_irq);

    // R7
    tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !tmo_irq);

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat && fifo_empty && !rd_len_hi && !rd_len_lo |-> rd_data[4] && rd_data[3:0] == 4'd0);

endmodule

bind rx_frame_status_fifo rfsf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .rd_stat    (rd_stat),
    .rd_len_hi  (rd_len_hi),
    .rd_len_lo  (rd_len_lo),
    .rd_data    (rd_data),
    .fifo_empty (fifo_empty),
    .thr_irq    (thr_irq),
    .tmo_irq    (tmo_irq),
    .occ        (occ)
);

// File: tb/sim_rx_frame_status_fifo.sv
`timescale 1ns/100ps
module sim_rx_frame_status_fifo;

    localparam int MS   = 40;
    localparam int DEP  = 8;
    localparam int WDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_end = 1'b0;
    logic [11:0] frame_len = '0;
    logic [3:0]  frame_err = '0;
    logic [1:0]  thr_sel = '0;
    logic        rd_len_hi = 1'b0;
    logic        rd_len_lo = 1'b0;
    logic        rd_stat = 1'b0;
    logic [7:0]  rd_data;
    logic        fifo_empty, thr_irq, tmo_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rx_frame_status_fifo #(.CYC_PER_MS(MS)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_len(frame_len),
        .frame_err(frame_err), .thr_sel(thr_sel), .rd_len_hi(rd_len_hi),
        .rd_len_lo(rd_len_lo), .rd_stat(rd_stat), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .thr_irq(thr_irq), .tmo_irq(tmo_irq)
    );

    // Behavioural reference model
    typedef struct { int len; int err; } ent_t;
    ent_t q[$];
    bit   m_ovf = 1'b0;
    int   m_tmr = 0;

    function automatic int level(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 7;
            default: return 8;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_ovf = 1'b0;
            m_tmr = 0;
        end else begin
            bit was_full, popped;
            was_full = (q.size() == DEP);
            popped   = rd_stat && (q.size() > 0);
            if (popped) void'(q.pop_front());
            if (frame_end && !was_full) q.push_back('{int'(frame_len), int'(frame_err)});
            if (frame_end && was_full) m_ovf = 1'b1;
            else if (rd_stat) m_ovf = 1'b0;
            if (frame_end || popped) m_tmr = 0;
            else if (m_tmr < MS) m_tmr++;
        end
    end

    function automatic int exp_rd();
        int st;
        if (rd_len_hi) return q.size() > 0 ? (q[0].len >> 8) : 0;
        if (rd_len_lo) return q.size() > 0 ? (q[0].len & 255) : 0;
        if (rd_stat) begin
            st = (q.size() > 0) ? q[0].err : 16;
            if (m_ovf) st += 32;
            return st;
        end
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 fifo_empty", int'(fifo_empty), int'(q.size() == 0));
            chk("R6 thr_irq", int'(thr_irq), int'(q.size() >= level(int'(thr_sel))));
            chk("R7 tmo_irq", int'(tmo_irq),
                int'(m_tmr == MS && q.size() > 0 && q.size() < level(int'(thr_sel))));
            chk("R3 rd_data", int'(rd_data), exp_rd());
        end
    end

    task automatic push(input int len, input int err);
        @(posedge clk); #1;
        frame_end = 1'b1; frame_len = 12'(len); frame_err = 4'(err);
        @(posedge clk); #1;
        frame_end = 1'b0;
    endtask

    task automatic read_entry(output int h, output int l, output int s);
        @(posedge clk); #1; rd_len_hi = 1'b1;
        @(negedge clk); h = int'(rd_data);
        @(posedge clk); #1; rd_len_hi = 1'b0; rd_len_lo = 1'b1;
        @(negedge clk); l = int'(rd_data);
        @(posedge clk); #1; rd_len_lo = 1'b0; rd_stat = 1'b1;
        @(negedge clk); s = int'(rd_data);
        @(posedge clk); #1; rd_stat = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int h, l, s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", int'(fifo_empty), 1);
        chk("R1 thr_irq", int'(thr_irq), 0);
        chk("R1 tmo_irq", int'(tmo_irq), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        @(posedge clk); #1; rst_n = 1'b1;

        // Idle time-out below level 4 (R7, R2)
        thr_sel = 2'd1;
        push(12'h3A5, 2);
        push(12'h010, 0);
        push(12'hFFF, 9);
        @(negedge clk);
        chk("R6 below level", int'(thr_irq), 0);
        chk("R7 not yet", int'(tmo_irq), 0);
        repeat (MS + 5) @(posedge clk);
        @(negedge clk);
        chk("R7 idle fired", int'(tmo_irq), 1);
        push(12'h801, 1);
        @(negedge clk);
        chk("R6 level 4 reached", int'(thr_irq), 1);
        chk("R7 cleared by frame", int'(tmo_irq), 0);

        // Drain in order (R3, R4, R2)
        read_entry(h, l, s);
        chk("R3 hi byte", h, 8'h03); chk("R3 lo byte", l, 8'hA5); chk("R3 status", s, 8'h02);
        @(negedge clk);
        chk("R4 pop lowers count", int'(thr_irq), 0);
        read_entry(h, l, s);
        chk("R2 order 2 lo", l, 8'h10); chk("R2 order 2 hi", h, 0);
        read_entry(h, l, s);
        chk("R2 order 3 hi", h, 8'h0F); chk("R2 order 3 st", s, 8'h09);
        read_entry(h, l, s);
        chk("R2 order 4 hi", h, 8'h08); chk("R2 order 4 lo", l, 8'h01);
        @(negedge clk);
        chk("R9 empty after drain", int'(fifo_empty), 1);
        @(posedge clk); #1; rd_stat = 1'b1;
        @(negedge clk);
        chk("R5 empty status", int'(rd_data), 8'h10);
        @(posedge clk); #1; rd_stat = 1'b0;
        @(negedge clk);
        chk("R5 still empty", int'(fifo_empty), 1);

        // Level codes (R6)
        thr_sel = 2'd0;
        push(1, 0);
        @(negedge clk);
        chk("R6 level 1", int'(thr_irq), 1);
        thr_sel = 2'd2;
        for (int i = 0; i < 5; i++) push(16 + i, i);
        @(negedge clk);
        chk("R6 six below 7", int'(thr_irq), 0);
        push(21, 5);
        @(negedge clk);
        chk("R6 level 7", int'(thr_irq), 1);
        thr_sel = 2'd3;
        @(negedge clk);
        chk("R6 seven below 8", int'(thr_irq), 0);
        push(22, 6);
        @(negedge clk);
        chk("R6 level 8", int'(thr_irq), 1);

        // Overflow (R8)
        push(12'h123, 7);
        read_entry(h, l, s);
        chk("R8 overflow flag shown", s & 8'h20, 8'h20);
        chk("R8 head kept", l, 1);
        read_entry(h, l, s);
        chk("R8 overflow flag cleared", s & 8'h20, 0);
        for (int i = 0; i < 6; i++) read_entry(h, l, s);
        chk("R8 last stored entry", l, 22);
        @(negedge clk);
        chk("R8 dropped frame absent", int'(fifo_empty), 1);

        // Simultaneous write and removal (R10)
        push(12'h0AA, 3);
        @(posedge clk); #1;
        frame_end = 1'b1; frame_len = 12'h055; frame_err = 4'd4; rd_stat = 1'b1;
        @(negedge clk);
        chk("R10 old status", int'(rd_data), 8'h03);
        @(posedge clk); #1;
        frame_end = 1'b0; rd_stat = 1'b0;
        @(negedge clk);
        chk("R10 not empty", int'(fifo_empty), 0);
        read_entry(h, l, s);
        chk("R10 new head", l, 8'h55);
        chk("R10 new status", s, 8'h04);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule